// File: doc/BRIEF.md
# Rename Table with Deferred History-Walk Recovery

This block is the register rename stage of an out-of-order core. It keeps one mapping entry per logical register in a directly indexed table, so each source lookup is a plain read with no associative search. Destination registers take fresh physical registers from a circular queue of free identifiers. Every renamed instruction gets one slot in an in-order history buffer, whether or not it writes a register. That slot records the destination's logical index, the mapping it replaced and the register it was given. The slot index is returned as the instruction's tag.

When an instruction retires, the oldest history slot is released, and the physical register its destination replaced goes back to the free queue. Any history slot can be marked as mispredicted. Nothing happens at once: recovery waits until the marked slot is the oldest in flight. The block then stalls rename and walks back over the younger slots, newest first, one per cycle. For each one it writes the old mapping back into the table and returns the register that slot had taken. The marked instruction itself stays, with its own rename kept, and retires normally later.

The configuration is 16 logical registers, 48 physical registers (32 free queue slots) and 40 history slots.

Top module: `rrn_rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i, the next destination allocation yields physical register 16, the next tag is 0, `busy` is low and `ren_ready` is high.
- R2: Each source output is the table entry at the given logical index in the same cycle. A source that names the same instruction's destination returns the mapping from before that instruction.
- R3: An accepted rename with `ren_has_dst` high receives the identifier at the free queue head, shown on `ren_phys_dst` in that cycle. Identifiers come out in FIFO order, first 16, 17, ... 47 after reset. Tags count up from 0 by one per accepted rename and wrap from 39 to 0.
- R4: After a rename with a destination is accepted, later source reads of that logical register return the newly allocated physical register.
- R5: A commit, taken when `commit_valid` is high, `busy` is low and the history is not empty, removes the oldest slot. If that slot wrote a destination, the physical register it replaced is appended to the tail of the free queue.
- R6: With 40 instructions in flight, `ren_ready` is low and a presented rename changes no state. It is accepted again once a commit has freed a slot.
- R7: With the free queue empty, `ren_ready` is low even when history slots remain. It is accepted again once a commit has released a register.
- R8: Marking a slot that is not the oldest in flight leaves `busy` low and rename proceeding. Recovery starts only when the marked slot becomes the oldest.
- R9: While the oldest slot is marked, `busy` is high and `ren_ready` is low. With N younger slots, `busy` stays high for exactly N+1 cycles. Each of the first N cycles undoes the youngest remaining slot: its old mapping is written back and its allocated register is appended to the free queue, so registers return newest first.
- R10: `commit_valid` is ignored while `busy` is high. After recovery the marked slot is the only one in flight, and the next tag is the marked tag plus one (mod 40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | An instruction is presented for rename |
| ren_src_a | input | 4 | First source logical register |
| ren_src_b | input | 4 | Second source logical register |
| ren_has_dst | input | 1 | The instruction writes a destination |
| ren_dst | input | 4 | Destination logical register |
| ren_ready | output | 1 | Rename can accept this cycle |
| ren_phys_a | output | 6 | Physical register for the first source |
| ren_phys_b | output | 6 | Physical register for the second source |
| ren_phys_dst | output | 6 | Physical register allocated to the destination |
| ren_tag | output | 6 | History slot given to the instruction |
| commit_valid | input | 1 | Retire the oldest instruction in flight |
| flag_valid | input | 1 | Mark a history slot as mispredicted |
| flag_tag | input | 6 | Tag of the slot to mark |
| busy | output | 1 | Recovery walk in progress |

## Verification
The assertions assume that a slot is marked only while it holds a live instruction, only while `busy` is low, and that at most one mark is outstanding at a time. They also assume no mark arrives in the cycle that recovery ends. The directed stimulus keeps to this: it marks a live tag once, in a quiet cycle, and does not mark again until `busy` has fallen. Commits are issued only when the bench's own model has instructions in flight. During the walk, commit and rename are both held high on purpose, to show they are ignored.

// File: rtl/rrn_pkg.sv
package rrn_pkg;

    // Configuration of the rename stage
    localparam int LOG_REGS   = 16;
    localparam int PHYS_REGS  = 48;
    localparam int HIST_DEPTH = 40;

    // Derived sizes
    localparam int FREE_DEPTH = PHYS_REGS - LOG_REGS;
    localparam int LOG_W      = $clog2(LOG_REGS);
    localparam int PHYS_W     = $clog2(PHYS_REGS);
    localparam int TAG_W      = $clog2(HIST_DEPTH);
    localparam int CNT_W      = $clog2(HIST_DEPTH + 1);

    typedef logic [LOG_W-1:0]  lreg_t;
    typedef logic [PHYS_W-1:0] preg_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // One history slot: enough to undo or retire the instruction
    typedef struct packed {
        logic  has_dst;
        lreg_t dst;
        preg_t prev;
        preg_t alloc;
    } hrec_t;

    function automatic tag_t tag_next(tag_t t);
        if (t == tag_t'(HIST_DEPTH - 1)) return '0;
        return tag_t'(t + 1'b1);
    endfunction

    function automatic tag_t tag_prev(tag_t t);
        if (t == '0) return tag_t'(HIST_DEPTH - 1);
        return tag_t'(t - 1'b1);
    endfunction

endpackage

// File: rtl/rrn_free_queue.sv
module rrn_free_queue
    import rrn_pkg::*;
#(
    parameter int DEPTH    = FREE_DEPTH,
    parameter int FIRST_ID = LOG_REGS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pop,
    input  logic  push,
    input  preg_t push_id,
    output preg_t head_id,
    output logic  empty
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH + 1);

    preg_t              slots [DEPTH];
    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W-1:0]   wr_ptr;
    logic [FILL_W-1:0]  fill;

    function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return PTR_W'(p + 1'b1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= preg_t'(FIRST_ID + i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= FILL_W'(DEPTH);
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_id;
                wr_ptr        <= ptr_next(wr_ptr);
            end
            if (pop) rd_ptr <= ptr_next(rd_ptr);
            fill <= FILL_W'(fill + FILL_W'(push) - FILL_W'(pop));
        end
    end

    assign head_id = slots[rd_ptr];
    assign empty   = (fill == '0);

endmodule

// File: rtl/rrn_map_table.sv
module rrn_map_table
    import rrn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lreg_t rd_a,
    input  lreg_t rd_b,
    input  lreg_t rd_d,
    output preg_t val_a,
    output preg_t val_b,
    output preg_t val_d,
    input  logic  wr_en,
    input  lreg_t wr_idx,
    input  preg_t wr_val
);
    preg_t tbl [LOG_REGS];

    // One register per logical entry with its own write decode
    for (genvar g = 0; g < LOG_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                tbl[g] <= preg_t'(g);
            else if (wr_en && wr_idx == lreg_t'(g))
                tbl[g] <= wr_val;
        end
    end

    // Reads see the table before this cycle's write
    assign val_a = tbl[rd_a];
    assign val_b = tbl[rd_b];
    assign val_d = tbl[rd_d];

endmodule

// File: rtl/rrn_hist_buf.sv
module rrn_hist_buf
    import rrn_pkg::*;
#(
    parameter int DEPTH = HIST_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  hrec_t push_rec,
    input  logic  pop_head,
    input  logic  pop_tail,
    input  logic  mark_en,
    input  tag_t  mark_tag,
    input  logic  clr_head_flag,
    output tag_t  tail_tag,
    output logic  head_has_dst,
    output preg_t head_prev,
    output logic  head_flag,
    output hrec_t last_rec,
    output cnt_t  count,
    output logic  full,
    output logic  empty
);
    hrec_t            ent [DEPTH];
    logic [DEPTH-1:0] flg;
    tag_t             hd;
    tag_t             tl;
    cnt_t             cnt;

    always_ff @(posedge clk) begin
        if (push) ent[tl] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hd  <= '0;
            tl  <= '0;
            cnt <= '0;
            flg <= '0;
        end else begin
            if (push)
                tl <= tag_next(tl);
            else if (pop_tail)
                tl <= tag_prev(tl);
            if (pop_head) hd <= tag_next(hd);
            cnt <= cnt_t'(cnt + cnt_t'(push) - cnt_t'(pop_head) - cnt_t'(pop_tail));
            if (push)          flg[tl]       <= 1'b0;
            if (mark_en)       flg[mark_tag] <= 1'b1;
            if (clr_head_flag) flg[hd]       <= 1'b0;
        end
    end

    assign tail_tag     = tl;
    assign head_has_dst = ent[hd].has_dst;
    assign head_prev    = ent[hd].prev;
    assign head_flag    = flg[hd];
    assign last_rec     = ent[tag_prev(tl)];
    assign count        = cnt;
    assign full         = (cnt == cnt_t'(DEPTH));
    assign empty        = (cnt == '0);

endmodule

// File: rtl/rrn_rename_unit.sv
module rrn_rename_unit
    import rrn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ren_valid,
    input  logic [LOG_W-1:0]  ren_src_a,
    input  logic [LOG_W-1:0]  ren_src_b,
    input  logic              ren_has_dst,
    input  logic [LOG_W-1:0]  ren_dst,
    output logic              ren_ready,
    output logic [PHYS_W-1:0] ren_phys_a,
    output logic [PHYS_W-1:0] ren_phys_b,
    output logic [PHYS_W-1:0] ren_phys_dst,
    output logic [TAG_W-1:0]  ren_tag,
    input  logic              commit_valid,
    input  logic              flag_valid,
    input  logic [TAG_W-1:0]  flag_tag,
    output logic              busy
);
    // Free queue
    preg_t fq_head;
    logic  fq_empty;
    logic  fq_pop;
    logic  fq_push;
    preg_t fq_push_id;

    // Map table
    preg_t map_old_dst;
    logic  map_wr_en;
    lreg_t map_wr_idx;
    preg_t map_wr_val;

    // History buffer
    hrec_t new_rec;
    logic  head_has_dst;
    preg_t head_prev;
    logic  head_flag;
    hrec_t last_rec;
    cnt_t  hist_count;
    logic  hist_full;
    logic  hist_empty;

    // Control
    logic ren_fire;
    logic commit_fire;
    logic undo_fire;
    logic walk_done;

    assign busy        = head_flag && !hist_empty;
    assign ren_ready   = !busy && !hist_full && !fq_empty;
    assign ren_fire    = ren_valid && ren_ready;
    assign commit_fire = commit_valid && !busy && !hist_empty;
    assign undo_fire   = busy && (hist_count > cnt_t'(1));
    assign walk_done   = busy && (hist_count == cnt_t'(1));

    // Table write: a new mapping on rename, or the old one during the walk
    always_comb begin
        map_wr_en  = 1'b0;
        map_wr_idx = ren_dst;
        map_wr_val = fq_head;
        if (ren_fire && ren_has_dst) begin
            map_wr_en = 1'b1;
        end else if (undo_fire && last_rec.has_dst) begin
            map_wr_en  = 1'b1;
            map_wr_idx = last_rec.dst;
            map_wr_val = last_rec.prev;
        end
    end

    // Free queue return: the replaced register at commit, the taken one on undo
    always_comb begin
        fq_push    = 1'b0;
        fq_push_id = head_prev;
        if (commit_fire && head_has_dst) begin
            fq_push = 1'b1;
        end else if (undo_fire && last_rec.has_dst) begin
            fq_push    = 1'b1;
            fq_push_id = last_rec.alloc;
        end
    end

    assign fq_pop  = ren_fire && ren_has_dst;
    assign new_rec = '{has_dst: ren_has_dst, dst: ren_dst, prev: map_old_dst, alloc: fq_head};

    rrn_free_queue #(
        .DEPTH    (FREE_DEPTH),
        .FIRST_ID (LOG_REGS)
    ) free_q_i (
        .clk     (clk),
        .rst     (rst),
        .pop     (fq_pop),
        .push    (fq_push),
        .push_id (fq_push_id),
        .head_id (fq_head),
        .empty   (fq_empty)
    );

    rrn_map_table map_i (
        .clk    (clk),
        .rst    (rst),
        .rd_a   (ren_src_a),
        .rd_b   (ren_src_b),
        .rd_d   (ren_dst),
        .val_a  (ren_phys_a),
        .val_b  (ren_phys_b),
        .val_d  (map_old_dst),
        .wr_en  (map_wr_en),
        .wr_idx (map_wr_idx),
        .wr_val (map_wr_val)
    );

    rrn_hist_buf #(
        .DEPTH (HIST_DEPTH)
    ) hist_i (
        .clk           (clk),
        .rst           (rst),
        .push          (ren_fire),
        .push_rec      (new_rec),
        .pop_head      (commit_fire),
        .pop_tail      (undo_fire),
        .mark_en       (flag_valid),
        .mark_tag      (flag_tag),
        .clr_head_flag (walk_done),
        .tail_tag      (ren_tag),
        .head_has_dst  (head_has_dst),
        .head_prev     (head_prev),
        .head_flag     (head_flag),
        .last_rec      (last_rec),
        .count         (hist_count),
        .full          (hist_full),
        .empty         (hist_empty)
    );

    assign ren_phys_dst = fq_head;

endmodule

// File: rtl/rrn_rename_checker.sv
module rrn_rename_checker
    import rrn_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ren_valid,
    input logic       ren_ready,
    input tag_t       ren_tag,
    input logic       commit_valid,
    input logic       flag_valid,
    input logic       busy,
    input cnt_t       hist_count,
    input logic       hist_full,
    input logic       fq_empty
);
    // R9: no rename is accepted while the walk runs
    p_stall_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ren_ready);

    // R3: an accepted rename advances the tag by one slot
    p_tag_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_ready) |=> ren_tag == tag_next($past(ren_tag)));

    // R9: each undo step retracts the tail by one slot
    p_walk_tag_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && hist_count > cnt_t'(1)) |=> ren_tag == tag_prev($past(ren_tag)));

    // R9: the walk ends once only the marked slot is left
    p_walk_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && hist_count == cnt_t'(1)) |=> !busy);

    // R10: a commit during the walk does not remove an extra slot
    p_commit_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && commit_valid && hist_count > cnt_t'(1))
            |=> hist_count == cnt_t'($past(hist_count) - 1));

    // R6: full history blocks rename
    p_full_stall_r6: assert property (@(posedge clk) disable iff (rst)
        hist_full |-> !ren_ready);

    // R7: empty free queue blocks rename
    p_empty_stall_r7: assert property (@(posedge clk) disable iff (rst)
        fq_empty |-> !ren_ready);

    // R8: input rule, marks arrive only outside a walk
    p_flag_idle_r8: assert property (@(posedge clk) disable iff (rst)
        flag_valid |-> !busy);

endmodule

bind rrn_rename_unit rrn_rename_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .ren_valid    (ren_valid),
    .ren_ready    (ren_ready),
    .ren_tag      (ren_tag),
    .commit_valid (commit_valid),
    .flag_valid   (flag_valid),
    .busy         (busy),
    .hist_count   (hist_count),
    .hist_full    (hist_full),
    .fq_empty     (fq_empty)
);

// File: tb/rrn_rename_unit_tb_top.sv
`timescale 1ns/1ps
module rrn_rename_unit_tb_top;
    import rrn_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ren_valid = 1'b0;
    lreg_t       ren_src_a = '0;
    lreg_t       ren_src_b = '0;
    logic        ren_has_dst = 1'b0;
    lreg_t       ren_dst = '0;
    logic        ren_ready;
    preg_t       ren_phys_a;
    preg_t       ren_phys_b;
    preg_t       ren_phys_dst;
    tag_t        ren_tag;
    logic        commit_valid = 1'b0;
    logic        flag_valid = 1'b0;
    tag_t        flag_tag = '0;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model built from the requirements
    int m_map [LOG_REGS];
    int m_fq[$];
    bit q_has[$];
    int q_dst[$];
    int q_prev[$];
    int q_new[$];
    int m_tag;

    always #2.5 clk = ~clk;

    rrn_rename_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .ren_valid    (ren_valid),
        .ren_src_a    (ren_src_a),
        .ren_src_b    (ren_src_b),
        .ren_has_dst  (ren_has_dst),
        .ren_dst      (ren_dst),
        .ren_ready    (ren_ready),
        .ren_phys_a   (ren_phys_a),
        .ren_phys_b   (ren_phys_b),
        .ren_phys_dst (ren_phys_dst),
        .ren_tag      (ren_tag),
        .commit_valid (commit_valid),
        .flag_valid   (flag_valid),
        .flag_tag     (flag_tag),
        .busy         (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ren_valid = 1'b0;
        commit_valid = 1'b0;
        flag_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LOG_REGS; i++) m_map[i] = i;
        m_fq.delete();
        for (int i = LOG_REGS; i < PHYS_REGS; i++) m_fq.push_back(i);
        q_has.delete(); q_dst.delete(); q_prev.delete(); q_new.delete();
        m_tag = 0;
    endtask

    task automatic rename_op(input int a, input int b, input bit hd, input int d, input string req);
        bit exp_ready;
        @(negedge clk);
        ren_valid   = 1'b1;
        ren_src_a   = lreg_t'(a);
        ren_src_b   = lreg_t'(b);
        ren_has_dst = hd;
        ren_dst     = lreg_t'(d);
        #1;
        exp_ready = (q_has.size() < HIST_DEPTH) && (m_fq.size() > 0);
        chk({req, " ready"}, int'(ren_ready), int'(exp_ready));
        if (exp_ready) begin
            chk({req, " src a"}, int'(ren_phys_a), m_map[a]);
            chk({req, " src b"}, int'(ren_phys_b), m_map[b]);
            chk({req, " tag"}, int'(ren_tag), m_tag);
            if (hd) chk({req, " dst alloc"}, int'(ren_phys_dst), m_fq[0]);
        end
        @(posedge clk);
        if (exp_ready) begin
            q_has.push_back(hd);
            q_dst.push_back(d);
            q_prev.push_back(m_map[d]);
            if (hd) begin
                q_new.push_back(m_fq[0]);
                m_map[d] = m_fq.pop_front();
            end else begin
                q_new.push_back(0);
            end
            m_tag = (m_tag + 1) % HIST_DEPTH;
        end
        #1 ren_valid = 1'b0;
    endtask

    task automatic commit_op();
        @(negedge clk);
        commit_valid = 1'b1;
        @(posedge clk);
        if (q_has.size() > 0) begin
            if (q_has[0]) m_fq.push_back(q_prev[0]);
            void'(q_has.pop_front()); void'(q_dst.pop_front());
            void'(q_prev.pop_front()); void'(q_new.pop_front());
        end
        #1 commit_valid = 1'b0;
    endtask

    task automatic mark_op(input int t);
        @(negedge clk);
        flag_valid = 1'b1;
        flag_tag   = tag_t'(t);
        @(posedge clk);
        #1 flag_valid = 1'b0;
    endtask

    // R1: state straight after reset
    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 busy", int'(busy), 0);
        chk("R1 ready", int'(ren_ready), 1);
        chk("R1 tag", int'(ren_tag), 0);
        chk("R1 first alloc", int'(ren_phys_dst), LOG_REGS);
        for (int i = 0; i < LOG_REGS; i++) begin
            ren_src_a = lreg_t'(i);
            #0.1;
            chk("R1 identity map", int'(ren_phys_a), i);
        end
    endtask

    // R2, R3, R4: lookups, same-instruction read, later reads
    task automatic t_basic();
        do_reset();
        rename_op(3, 3, 1'b1, 3, "R2 self source");
        rename_op(3, 5, 1'b1, 5, "R4 sees new map");
        rename_op(5, 3, 1'b0, 0, "R4 no dst");
        rename_op(7, 9, 1'b1, 7, "R3 third alloc");
        chk("R3 alloc order", m_fq[0], 19);
    endtask

    // R5: released registers join the free queue tail
    task automatic t_release();
        do_reset();
        for (int i = 0; i < 16; i++) rename_op(i, i, 1'b1, i, "R3 fill");
        for (int i = 0; i < 16; i++) commit_op();
        for (int i = 0; i < 32; i++) rename_op(0, 1, 1'b1, i % 16, "R5 reuse order");
    endtask

    // R6: history full blocks rename
    task automatic t_hist_full();
        do_reset();
        for (int i = 0; i < HIST_DEPTH; i++) rename_op(1, 2, 1'b0, 0, "R3 no-dst fill");
        chk("R6 history size", q_has.size(), HIST_DEPTH);
        rename_op(1, 2, 1'b0, 0, "R6 full stall");
        #1 chk("R6 ready while full", int'(ren_ready), 0);
        commit_op();
        rename_op(4, 2, 1'b1, 4, "R6 after commit");
        chk("R3 tag wrap", m_tag, 1);
    endtask

    // R7: empty free queue blocks rename
    task automatic t_free_empty();
        do_reset();
        for (int i = 0; i < FREE_DEPTH; i++) rename_op(0, 0, 1'b1, 2, "R3 drain");
        chk("R7 free empty", m_fq.size(), 0);
        rename_op(2, 0, 1'b1, 6, "R7 empty stall");
        commit_op();
        rename_op(2, 0, 1'b1, 6, "R7 after release");
    endtask

    // R8, R9, R10: deferred recovery walk
    task automatic t_recovery();
        int cnt;
        int n_young;
        do_reset();
        rename_op(0, 0, 1'b1, 1, "R8 older op");
        rename_op(1, 0, 1'b0, 0, "R8 branch");
        mark_op(1);
        rename_op(1, 2, 1'b1, 1, "R8 wrong path a");
        rename_op(1, 2, 1'b1, 2, "R8 wrong path b");
        rename_op(2, 1, 1'b1, 1, "R8 wrong path c");
        #1 chk("R8 busy with mark not oldest", int'(busy), 0);
        commit_op();
        n_young = q_has.size() - 1;
        @(negedge clk);
        commit_valid = 1'b1;
        ren_valid = 1'b1;
        #1;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            chk("R9 ready during walk", int'(ren_ready), 0);
            @(negedge clk);
            #1;
        end
        commit_valid = 1'b0;
        ren_valid = 1'b0;
        chk("R9 walk length", cnt, n_young + 1);
        while (q_has.size() > 1) begin
            if (q_has[$]) begin
                m_map[q_dst[$]] = q_prev[$];
                m_fq.push_back(q_new[$]);
            end
            void'(q_has.pop_back()); void'(q_dst.pop_back());
            void'(q_prev.pop_back()); void'(q_new.pop_back());
        end
        m_tag = 2;
        chk("R10 next tag", int'(ren_tag), 2);
        rename_op(1, 2, 1'b1, 5, "R9 restored map");
        commit_op();
        commit_op();
        for (int i = 0; i < 31; i++) rename_op(1, 2, 1'b1, 3, "R9 return order");
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_release();
        t_hist_full();
        t_free_empty();
        t_recovery();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule